// File: doc/BRIEF.md
# VCO Band Calibration Sequencer

This block picks which of three oscillator bands (low, middle, high) the frequency synthesizer uses. It runs a calibration along the radio's slot timeline. The middle band is selected first. During the locking period of one blind slot, the divider is forced to the lower border of the extended band. During the locking period of the next blind slot, it is forced to the upper border. At the end of each locking period, two comparator flags on the charge-pump voltage show whether the loop reached its target. From these two results the block chooses the band.

While calibration runs, the block takes over the main divider value through an override enable and an override value. It also raises a mask that suppresses the active slots after the two calibration blind slots, so the transmit and receive pin-diode drivers stay off. Calibration starts on its own after reset. Software can request it again by writing a control bit high and then low. A request that arrives during a calibration aborts that calibration and starts a new one.

Top module: `vco_band_cal`

## Requirements
- R1: After reset, the band output reads middle (band encoding: 2'b00 low, 2'b01 middle, 2'b10 high), the override enable and the mask are low, and a calibration is pending.
- R2: A blind-slot start pulse while a calibration is pending and none is running starts the low probe from the next cycle: override enable high, override value DIV_LO, mask high.
- R3: The lock-end pulse in the low probe drops the override while the mask stays high. The next blind-slot start begins the high probe, with override value DIV_HI.
- R4: The lock-end pulse of the high probe sets the band. Low-edge failure only (cp_under was high at the low lock-end) gives low. High-edge failure only (cp_over high at the high lock-end) gives high. Neither or both gives middle.
- R5: The band reads middle from the start of a calibration until its decision, and it holds its value between calibrations.
- R6: The mask stays high from the start of the low probe until the active-slot end pulse that follows the high probe, and it drops on the cycle after that pulse.
- R7: Writing the request bit to 1 only arms a recalibration. The following 1-to-0 transition makes a calibration pending, and it starts at the next blind-slot start.
- R8: A 1-to-0 transition of the request bit during a calibration aborts it: the override and the mask drop on the next cycle, and a fresh calibration starts at the next blind-slot start.
- R9: Slot events arriving in a phase that does not expect them are ignored: lock-end or active-end while idle, active-end during a probe, and blind-start during the closing active slot.
- R10: The comparator flags have no effect except in the cycle of a lock-end pulse during a probe.
- R11: A blind-slot start with no calibration pending changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| blind_start_i | input | 1 | One-cycle pulse at the start of a blind slot's locking period |
| lock_end_i | input | 1 | One-cycle pulse at the end of the locking period |
| active_end_i | input | 1 | One-cycle pulse at the end of an active slot |
| recal_req_i | input | 1 | Recalibration control bit (level) |
| cp_under_i | input | 1 | Charge-pump voltage is below its valid range |
| cp_over_i | input | 1 | Charge-pump voltage is above its valid range |
| band_o | output | 2 | Selected oscillator band |
| div_ovr_en_o | output | 1 | Main divider override enable |
| div_ovr_val_o | output | DIV_W | Main divider override value |
| slot_mask_o | output | 1 | Suppresses the active slot and the pin-diode drivers |

## Verification
The bench uses the default parameters: a 12-bit divider with border ratios of 2176 and 2303. These values let every override value be checked exactly at the port. A behavioural reference model predicts the band, the override and the mask on every clock. Directed sequences cover all four combinations of probe outcome, recalibration arming and abort during a probe, and slot events that arrive out of phase. They also toggle the comparator flags away from the lock-end sample point.

// File: rtl/vcal_pkg.sv
package vcal_pkg;
  typedef enum logic [1:0] {
    BAND_LOW  = 2'b00,
    BAND_MID  = 2'b01,
    BAND_HIGH = 2'b10
  } band_e;

  typedef enum logic [2:0] {
    SQ_IDLE     = 3'd0,
    SQ_PROBE_LO = 3'd1,
    SQ_WAIT_HI  = 3'd2,
    SQ_PROBE_HI = 3'd3,
    SQ_CLOSE    = 3'd4
  } seq_e;
endpackage

// File: rtl/vcal_req_track.sv
module vcal_req_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic recal_req_i,
  input  logic start_i,
  output logic trig_o,
  output logic pend_o
);
  logic req_q, req_d;
  logic pend_q, pend_d;

  always_comb begin
    trig_o = req_q & ~recal_req_i;
    req_d  = recal_req_i;
    pend_d = trig_o | (pend_q & ~start_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b1;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  p_trig_pends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> pend_q);
  p_pend_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !start_i) |=> pend_q);
endmodule

// File: rtl/vcal_seq_fsm.sv
module vcal_seq_fsm
  import vcal_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int DIV_LO = 2176,
  parameter int DIV_HI = 2303
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blind_start_i,
  input  logic             lock_end_i,
  input  logic             active_end_i,
  input  logic             cp_under_i,
  input  logic             trig_i,
  input  logic             pend_i,
  output logic             start_o,
  output logic             decide_o,
  output logic             lo_fail_o,
  output logic             ovr_en_o,
  output logic [DIV_W-1:0] ovr_val_o,
  output logic             mask_o
);
  localparam logic [DIV_W-1:0] LoVal = DIV_W'(DIV_LO);
  localparam logic [DIV_W-1:0] HiVal = DIV_W'(DIV_HI);

  seq_e state_q, state_d;
  logic lo_q, lo_d;

  always_comb begin
    state_d  = state_q;
    lo_d     = lo_q;
    start_o  = 1'b0;
    decide_o = 1'b0;
    if (trig_i) begin
      state_d = SQ_IDLE;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (blind_start_i && pend_i) begin
          start_o = 1'b1;
          state_d = SQ_PROBE_LO;
        end
        SQ_PROBE_LO: if (lock_end_i) begin
          lo_d    = cp_under_i;
          state_d = SQ_WAIT_HI;
        end
        SQ_WAIT_HI: if (blind_start_i) state_d = SQ_PROBE_HI;
        SQ_PROBE_HI: if (lock_end_i) begin
          decide_o = 1'b1;
          state_d  = SQ_CLOSE;
        end
        SQ_CLOSE: if (active_end_i) state_d = SQ_IDLE;
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      lo_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      lo_q    <= lo_d;
    end
  end

  always_comb begin
    ovr_en_o  = (state_q == SQ_PROBE_LO) || (state_q == SQ_PROBE_HI);
    ovr_val_o = '0;
    if (state_q == SQ_PROBE_LO) ovr_val_o = LoVal;
    if (state_q == SQ_PROBE_HI) ovr_val_o = HiVal;
    mask_o    = (state_q != SQ_IDLE);
  end
  assign lo_fail_o = lo_q;

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_IDLE && pend_i && blind_start_i && !trig_i) |=> (state_q == SQ_PROBE_LO));
  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (state_q == SQ_IDLE && !ovr_en_o));
  p_ovr_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_en_o |-> mask_o);
  p_close_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_CLOSE && active_end_i) |=> !mask_o);
endmodule

// File: rtl/vcal_band_reg.sv
module vcal_band_reg
  import vcal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       decide_i,
  input  logic       lo_fail_i,
  input  logic       hi_fail_i,
  output logic [1:0] band_o
);
  band_e band_q, band_d;

  always_comb begin
    band_d = band_q;
    if (start_i) begin
      band_d = BAND_MID;
    end else if (decide_i) begin
      unique case ({lo_fail_i, hi_fail_i})
        2'b10:   band_d = BAND_LOW;
        2'b01:   band_d = BAND_HIGH;
        default: band_d = BAND_MID;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) band_q <= BAND_MID;
    else         band_q <= band_d;
  end

  assign band_o = band_q;

  p_band_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    band_q != 2'b11);
  p_band_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !decide_i) |=> $stable(band_q));
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal #(
  parameter int DIV_W  = 12,
  parameter int DIV_LO = 2176,
  parameter int DIV_HI = 2303
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blind_start_i,
  input  logic             lock_end_i,
  input  logic             active_end_i,
  input  logic             recal_req_i,
  input  logic             cp_under_i,
  input  logic             cp_over_i,
  output logic [1:0]       band_o,
  output logic             div_ovr_en_o,
  output logic [DIV_W-1:0] div_ovr_val_o,
  output logic             slot_mask_o
);
  logic trig, pend, start, decide, lo_fail;

  vcal_req_track u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .recal_req_i(recal_req_i),
    .start_i    (start),
    .trig_o     (trig),
    .pend_o     (pend)
  );

  vcal_seq_fsm #(
    .DIV_W (DIV_W),
    .DIV_LO(DIV_LO),
    .DIV_HI(DIV_HI)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .blind_start_i(blind_start_i),
    .lock_end_i   (lock_end_i),
    .active_end_i (active_end_i),
    .cp_under_i   (cp_under_i),
    .trig_i       (trig),
    .pend_i       (pend),
    .start_o      (start),
    .decide_o     (decide),
    .lo_fail_o    (lo_fail),
    .ovr_en_o     (div_ovr_en_o),
    .ovr_val_o    (div_ovr_val_o),
    .mask_o       (slot_mask_o)
  );

  vcal_band_reg u_band (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .decide_i (decide),
    .lo_fail_i(lo_fail),
    .hi_fail_i(cp_over_i),
    .band_o   (band_o)
  );
endmodule

// File: tb/vco_band_cal_tb.sv
module vco_band_cal_tb_top;
  localparam int W = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic blind = 0, lock = 0, aend = 0, recal = 0, under = 0, over = 0;
  logic [1:0] band;
  logic ovr_en, mask;
  logic [W-1:0] ovr_val;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vco_band_cal dut_i (
    .clk_i(clk), .rst_ni(rst_n), .blind_start_i(blind), .lock_end_i(lock),
    .active_end_i(aend), .recal_req_i(recal), .cp_under_i(under), .cp_over_i(over),
    .band_o(band), .div_ovr_en_o(ovr_en), .div_ovr_val_o(ovr_val), .slot_mask_o(mask)
  );

  // behavioural reference: phase 0 idle, 1 low probe, 2 between, 3 high probe, 4 closing slot
  int m_ph = 0, m_band = 1;
  bit m_pend = 1, m_lof = 0, m_prev = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_pend = 1; m_band = 1; m_lof = 0; m_prev = 0;
    end else begin
      bit fall;
      fall = m_prev && !recal;
      m_prev = recal;
      if (fall) begin m_ph = 0; m_pend = 1; end
      else if (m_ph == 0 && blind && m_pend) begin m_ph = 1; m_pend = 0; m_band = 1; end
      else if (m_ph == 1 && lock) begin m_lof = under; m_ph = 2; end
      else if (m_ph == 2 && blind) m_ph = 3;
      else if (m_ph == 3 && lock) begin
        m_band = (m_lof && !over) ? 0 : (!m_lof && over) ? 2 : 1;
        m_ph = 4;
      end
      else if (m_ph == 4 && aend) m_ph = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check(band == 2'(m_band), "R4/R5 band", band, m_band);
      check(ovr_en == (m_ph == 1 || m_ph == 3), "R2/R3 ovr_en", ovr_en, (m_ph == 1 || m_ph == 3));
      if (m_ph == 1) check(ovr_val == W'(2176), "R2 ovr_val", ovr_val, 2176);
      if (m_ph == 3) check(ovr_val == W'(2303), "R3 ovr_val", ovr_val, 2303);
      check(mask == (m_ph != 0), "R6 mask", mask, m_ph != 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic pulse_blind(); blind = 1; step(1); blind = 0; endtask
  task automatic pulse_aend();  aend = 1;  step(1); aend = 0;  endtask
  task automatic pulse_lock(input bit u, input bit o);
    under = u; over = o; lock = 1; step(1); lock = 0; under = 0; over = 0;
  endtask
  task automatic full_cal(input bit u, input bit o, input int exp_band, input string req);
    pulse_blind(); step(2);
    pulse_lock(u, 0); step(2);
    pulse_blind(); step(2);
    pulse_lock(0, o); step(1);
    check(band == 2'(exp_band), req, band, exp_band);
    pulse_aend();
    check(!mask, "R6 mask clears", mask, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    check(band == 2'b01 && !ovr_en && !mask, "R1 reset state", {band, ovr_en, mask}, 4);
    // R9: stray events while idle
    pulse_lock(1, 1); pulse_aend(); step(1);
    check(!mask && band == 2'b01, "R9 idle ignores events", mask, 0);
    // power-up calibration pending (R1), starts at blind (R2)
    pulse_blind();
    check(ovr_en && ovr_val == W'(2176) && mask, "R2 low probe", ovr_val, 2176);
    pulse_aend();
    check(ovr_en, "R9 active-end in probe ignored", ovr_en, 1);
    under = 1; over = 1; step(2); under = 0; over = 0;
    check(ovr_en && band == 2'b01, "R10 flags outside lock-end", band, 1);
    pulse_lock(1, 0);
    check(!ovr_en && mask, "R3 override drops, mask held", {ovr_en, mask}, 1);
    pulse_blind();
    check(ovr_en && ovr_val == W'(2303), "R3 high probe", ovr_val, 2303);
    check(band == 2'b01, "R5 middle during calibration", band, 1);
    pulse_lock(0, 0);
    check(band == 2'b00, "R4 low-edge fail gives low", band, 0);
    pulse_blind();
    check(mask && !ovr_en, "R9 blind in closing slot ignored", ovr_en, 0);
    pulse_aend();
    check(!mask, "R6 mask clears after active end", mask, 0);
    // R10 / R11 / R5
    under = 1; over = 1; step(3); under = 0; over = 0;
    pulse_blind();
    check(!mask && !ovr_en && band == 2'b00, "R11 blind without pending", band, 0);
    check(band == 2'b00, "R5 band holds", band, 0);
    // R7: arm then trigger
    recal = 1; step(2); pulse_blind();
    check(!mask, "R7 armed only", mask, 0);
    recal = 0; step(2);
    check(!mask, "R7 waits for blind", mask, 0);
    full_cal(0, 1, 2, "R4 high-edge fail gives high");
    recal = 1; step(1); recal = 0; step(1);
    full_cal(1, 1, 1, "R4 both fail gives middle");
    recal = 1; step(1); recal = 0; step(1);
    full_cal(0, 0, 1, "R4 no fail gives middle");
    // R8: abort during calibration
    recal = 1; step(1); recal = 0; step(1);
    pulse_blind(); step(1);
    recal = 1; step(1); recal = 0; step(1);
    check(!mask && !ovr_en, "R8 abort clears", mask, 0);
    pulse_blind();
    check(ovr_en && ovr_val == W'(2176), "R8 restart low probe", ovr_val, 2176);
    pulse_lock(0, 0); step(1);
    recal = 1; step(1); recal = 0; step(1);
    check(!mask, "R8 abort between probes", mask, 0);
    full_cal(1, 0, 0, "R4 low after restart");
    step(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule